// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block links two byte-wide ports, A and B. Data can pass in either direction, and each direction has its own holding register. Each direction has three active-low controls: an enable, a latch strobe and an output gate. While both the enable and the latch strobe of a direction are low, its holding register is open. The far port then shows the near port's data in the same cycle. When either strobe returns high, the register keeps the last value it took in and shows that value from then on.

The output-valid flag of a port is raised only when that direction's enable and output gate are both low. This means data can be captured while the port stays quiet, and shown later. There are no real tristate pads. Each port is a separate input bus, an output bus and a drive flag.

A synchronous reset stands in for power-up. It clears both registers and holds both drive flags low while it is asserted.

Top module: `latched_xcvr`

## Requirements
- R1: While `rst` is high, `a_oe` and `b_oe` are 0. After reset, both stored values are 0. They show on `b_out` and `a_out` when the direction's enable is 0 and its latch strobe is 1.
- R2: When a direction's enable and latch strobe are both 0, its output bus equals its input bus in the same cycle. `b_out` follows `a_in`, and `a_out` follows `b_in`. This holds whether or not the drive flag is raised.
- R3: If the latch strobe rises while the enable stays 0, the output bus shows the input value from the last cycle in which both strobes were 0.
- R4: If the enable rises while the latch strobe is 0, that same last-open-cycle value is captured. Because the enable is 1, the port is not driven. The value appears once the enable returns to 0 with the latch strobe held at 1.
- R5: A port's drive flag (`b_oe` for the A-to-B direction, `a_oe` for B-to-A) is 1 exactly when that direction's enable and output gate are both 0 and reset is low.
- R6: When a direction's output gate is 1, its drive flag is 0 whatever the enable and latch strobe are. Capture through the latch strobe still takes place.
- R7: While either strobe of a direction is 1, its output bus holds steady, however the input bus moves.
- R8: The two directions are independent. Activity on the B-to-A controls and data leaves the A-to-B stored value unchanged, and the reverse is also true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Data arriving on port A |
| a_out | output | WIDTH | Data presented toward port A |
| a_oe | output | 1 | Port A drive flag |
| b_in | input | WIDTH | Data arriving on port B |
| b_out | output | WIDTH | Data presented toward port B |
| b_oe | output | 1 | Port B drive flag |
| en_ab_n | input | 1 | A-to-B enable, active low |
| le_ab_n | input | 1 | A-to-B latch strobe, active low |
| oe_ab_n | input | 1 | A-to-B output gate, active low |
| en_ba_n | input | 1 | B-to-A enable, active low |
| le_ba_n | input | 1 | B-to-A latch strobe, active low |
| oe_ba_n | input | 1 | B-to-A output gate, active low |

## Verification
The hardest case to reach is a capture made by the enable rather than the latch strobe. The port is undriven at that moment, so the captured byte cannot be seen until the enable drops again with the latch strobe already high. The stimulus opens the register with the output gate high, raises the enable, and then changes the input. It then lowers the enable with the latch strobe high and the gate low, and checks that the earlier byte comes out. A cycle-level reference model is compared every cycle, including during the opposite direction's traffic. The bench also flags any cycle in which both drive flags are raised together.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int XCVR_WIDTH = 8;
    localparam int XCVR_LANES = 2;
    typedef enum logic {
        LANE_A2B = 1'b0,
        LANE_B2A = 1'b1
    } lane_e;
endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_n,
    input  logic             le_n,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);
    typedef struct packed {
        logic [WIDTH-1:0] held;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic        open_w;

    always_comb begin
        st_d   = st_q;
        open_w = ~(en_n | le_n) & ~rst;
        if (rst) begin
            st_d.held = '0;
        end else if (open_w) begin
            st_d.held = din;
        end
        dout  = open_w ? din : st_q.held;
        drive = ~(en_n | oe_n) & ~rst;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr #(
    parameter int WIDTH = xcvr_pkg::XCVR_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             en_ab_n,
    input  logic             le_ab_n,
    input  logic             oe_ab_n,
    input  logic             en_ba_n,
    input  logic             le_ba_n,
    input  logic             oe_ba_n
);
    import xcvr_pkg::*;
    localparam int LANES = XCVR_LANES;

    logic [LANES-1:0][WIDTH-1:0] src, dst;
    logic [LANES-1:0]            en_v, le_v, oe_v, drv_v;

    always_comb begin
        src[LANE_A2B]  = a_in;
        src[LANE_B2A]  = b_in;
        en_v[LANE_A2B] = en_ab_n;
        en_v[LANE_B2A] = en_ba_n;
        le_v[LANE_A2B] = le_ab_n;
        le_v[LANE_B2A] = le_ba_n;
        oe_v[LANE_A2B] = oe_ab_n;
        oe_v[LANE_B2A] = oe_ba_n;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xcvr_lane #(.WIDTH(WIDTH)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .en_n  (en_v[g]),
            .le_n  (le_v[g]),
            .oe_n  (oe_v[g]),
            .din   (src[g]),
            .dout  (dst[g]),
            .drive (drv_v[g])
        );
    end

    assign b_out = dst[LANE_A2B];
    assign b_oe  = drv_v[LANE_A2B];
    assign a_out = dst[LANE_B2A];
    assign a_oe  = drv_v[LANE_B2A];
endmodule

// File: rtl/latched_xcvr_chk.sv
module latched_xcvr_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_out,
    input logic             a_oe,
    input logic             b_oe,
    input logic             en_ab_n,
    input logic             le_ab_n,
    input logic             oe_ab_n,
    input logic             oe_ba_n
);
    logic up_q;
    always_ff @(posedge clk) up_q <= ~rst;

    AST_RESET_QUIET: assert property (@(posedge clk) rst |-> (!a_oe && !b_oe)); // R1
    AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!en_ab_n && !le_ab_n) |-> (b_out == a_in)); // R2
    AST_STROBE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (up_q && $past(!en_ab_n && !le_ab_n) && le_ab_n && !en_ab_n) |-> (b_out == $past(a_in))); // R3
    AST_GATE_B_OFF: assert property (@(posedge clk) disable iff (rst)
        oe_ab_n |-> !b_oe); // R6
    AST_GATE_A_OFF: assert property (@(posedge clk) disable iff (rst)
        oe_ba_n |-> !a_oe); // R6
    AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (up_q && $past(en_ab_n || le_ab_n) && (en_ab_n || le_ab_n)) |-> $stable(b_out)); // R7
endmodule

bind latched_xcvr latched_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .a_in(a_in), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe),
    .en_ab_n(en_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n)
);

// File: tb/latched_xcvr_bench.sv
module latched_xcvr_bench;
    logic       clk = 0;
    logic       rst;
    logic [7:0] a_in, b_in, a_out, b_out;
    logic       a_oe, b_oe;
    logic       en_ab_n, le_ab_n, oe_ab_n, en_ba_n, le_ba_n, oe_ba_n;
    int         checks = 0, fails = 0;
    bit         done = 0;
    int         held_ab = 0, held_ba = 0;

    always #2 clk = ~clk;

    latched_xcvr u_latched_xcvr (
        .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .en_ab_n(en_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
        .en_ba_n(en_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n)
    );

    task automatic expect_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ctl = {en_ab, le_ab, oe_ab, en_ba, le_ba, oe_ba}, all active low
    task automatic cyc(input string req, input bit r, input int a, input int b, input bit [5:0] ctl);
        int eb, ea, db, da;
        rst = r; a_in = 8'(a); b_in = 8'(b);
        {en_ab_n, le_ab_n, oe_ab_n, en_ba_n, le_ba_n, oe_ba_n} = ctl;
        @(negedge clk);
        eb = (!r && !ctl[5] && !ctl[3]) ? 1 : 0;
        ea = (!r && !ctl[2] && !ctl[0]) ? 1 : 0;
        db = (!r && !ctl[5] && !ctl[4]) ? (a & 255) : held_ab;
        da = (!r && !ctl[2] && !ctl[1]) ? (b & 255) : held_ba;
        expect_eq(req, "b_oe", int'(b_oe), eb);
        expect_eq(req, "a_oe", int'(a_oe), ea);
        if (!r) begin
            expect_eq(req, "b_out", int'(b_out), db);
            expect_eq(req, "a_out", int'(a_out), da);
        end
        expect_eq("R8", "contention", int'(a_oe && b_oe), 0);
        @(posedge clk);
        held_ab = r ? 0 : db;
        held_ba = r ? 0 : da;
        #1;
    endtask

    initial begin
        // R1: reset, then show the cleared values
        for (int i = 0; i < 3; i++) cyc("R1", 1, 8'hFF, 8'hEE, 6'b000000);
        cyc("R1", 0, 8'h11, 8'h22, 6'b010111);
        cyc("R1", 0, 8'h33, 8'h44, 6'b111010);
        // R2: transparent A to B, then B to A
        for (int i = 0; i < 4; i++) cyc("R2", 0, 8'h3C + i * 17, 0, 6'b000111);
        for (int i = 0; i < 4; i++) cyc("R2", 0, 0, 8'hA1 - i * 9, 6'b111000);
        // R3 + R7: latch strobe rises, data moves, output holds
        cyc("R3", 0, 8'h96, 0, 6'b000111);
        for (int i = 0; i < 4; i++) cyc("R7", 0, 8'h01 << i, 0, 6'b010111);
        // R5 / R6: gating of the drive flag
        cyc("R6", 0, 8'h77, 0, 6'b011111);
        cyc("R6", 0, 8'h78, 0, 6'b001111);
        cyc("R5", 0, 8'h79, 0, 6'b110111);
        cyc("R5", 0, 8'h7A, 0, 6'b100111);
        // R6: capture with the gate high (open, then strobe rises)
        cyc("R6", 0, 8'hC3, 0, 6'b001111);
        cyc("R6", 0, 8'h00, 0, 6'b011111);
        cyc("R6", 0, 8'h00, 0, 6'b010111);
        // R4: capture through the enable, port undriven, shown later
        cyc("R4", 0, 8'h5A, 0, 6'b001111);
        cyc("R4", 0, 8'hFF, 0, 6'b101111);
        cyc("R4", 0, 8'h0F, 0, 6'b111111);
        cyc("R4", 0, 8'hE1, 0, 6'b010111);
        cyc("R4", 0, 8'h1E, 0, 6'b110111);
        // R4 for B to A
        cyc("R4", 0, 0, 8'h6B, 6'b111001);
        cyc("R4", 0, 0, 8'h00, 6'b111101);
        cyc("R4", 0, 0, 8'h99, 6'b111010);
        // R8: B to A traffic leaves A to B storage alone
        for (int i = 0; i < 4; i++) cyc("R8", 0, 8'h80 + i, 8'h20 * i + 3, 6'b111000);
        cyc("R8", 0, 8'h44, 8'h55, 6'b110111);
        cyc("R8", 0, 8'h44, 8'h55, 6'b010111);
        // R1: reset again in the middle of traffic
        cyc("R1", 1, 8'hAB, 8'hCD, 6'b000000);
        cyc("R1", 0, 8'hAB, 8'hCD, 6'b010111);
        cyc("R1", 0, 8'hAB, 8'hCD, 6'b111010);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule